// File: doc/BRIEF.md
# Half-Period Timing Error Monitor

This block is a measurement harness for finding the propagation delay of an external chain of delay elements. A launch register toggles on every rising clock edge and drives the chain input. A second register samples the chain output on the falling edge, half a period later. At the next rising edge, the sampled level is compared with the level that was launched. The outcome is kept in a capture register for one cycle, as an error flag.

If the chain is faster than half a clock period, the sample always matches the launched level. If it is slower, the sample still holds the previous, stale level and every cycle reports an error. A clock sweep outside the block moves the half period across the path delay. The point where the error rate passes 50% gives the delay.

Two such sweeps are run: one with the last delay element's control inputs all high, and one with them all low. Their difference is the step size of that element.

A start pulse opens a counting window of a programmable number of cycles. Over that window the block counts the error flags. When the window closes it raises a done flag and holds both counts until the next start pulse.

Top module: `timing_err_monitor`

## Requirements
- R1: After reset the launch output is 0. On every rising clock edge that follows, it inverts.
- R2: The chain input is sampled on each falling edge. On the next rising edge, the error flag is loaded with (sampled level XOR launched level) and held for that one cycle. So the flag seen during the cycle after rising edge j reflects the transition launched at rising edge j-1.
- R3: When the chain delay is below half a clock period, the error flag stays 0. When it is above half a period, the error flag is 1 in every cycle, and a window of N cycles reports N errors.
- R4: A start pulse sampled at a rising edge clears both counts at that edge and latches the window length for the run.
- R5: While a window is open, each rising edge adds 1 to the cycle count and adds the current error flag to the error count. For a start at edge k, the counted flags are those loaded at edges k through k+N-1.
- R6: Done goes high exactly N rising edges after the start edge. With N = 0 it goes high at the start edge itself, with both counts 0. Done stays low while a window is open.
- R7: Once done is high, both counts and done hold their values until the next start pulse.
- R8: A start pulse during an open window abandons that window and begins a new one with the newly presented length.
- R9: During reset, the launch output, the error flag, both counts and done are all 0.
- R10: The error count never exceeds the cycle count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Measurement clock; launch and compare on rising edges, sampling on falling edges |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse that opens a counting window |
| windowLen | input | 16 | Window length N in cycles, latched on start |
| chainIn | input | 1 | Output of the external delay chain |
| launchOut | output | 1 | Toggling drive into the external delay chain |
| errFlag | output | 1 | Capture register: 1 when the last sample was stale |
| errCount | output | 16 | Errors counted in the current or last window |
| cycleCount | output | 16 | Cycles counted in the current or last window |
| done | output | 1 | High once the window has closed; counts are frozen |

## Verification
A launch or sample register on the wrong edge shows up within one or two cycles. The error flag disagrees with the per-edge delay pattern, so a patterned delay model in the bench catches it at once.

A wrong window state or a misplaced compare stage does not show up right away. It appears only when done rises: the error count is off by one edge-worth of flags, or done arrives one edge early or late. To pin the counted span to the exact launch edges, the bench checks the counts and the done edge after every window, under several delay patterns.

A window state that fails to freeze shows up as counts drifting after done.

// File: rtl/tem_pkg.sv
package tem_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } winState_t;

  typedef struct packed {
    logic clearCounts;
    logic accumulate;
  } ctlStrobe_t;

endpackage

// File: rtl/tem_datapath.sv
module tem_datapath
  import tem_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrobe_t       strobes,
  input  logic [CNT_W-1:0] windowLen,
  input  logic             chainIn,
  output logic             launchOut,
  output logic             errFlag,
  output logic [CNT_W-1:0] errCount,
  output logic [CNT_W-1:0] cycleCount,
  output logic             windowZero,
  output logic             windowEnd
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic             launchQ;
  logic             sampleQ;
  logic             captureQ;
  logic [CNT_W-1:0] limitQ;
  logic [CNT_W-1:0] cycleQ;
  logic [CNT_W-1:0] errQ;
  logic [CNT_W-1:0] cycleNext;

  // launch register: toggles on every rising edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) launchQ <= 1'b0;
    else       launchQ <= ~launchQ;
  end

  // sample register: opposite edge, half a period after launch
  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) sampleQ <= 1'b0;
    else       sampleQ <= chainIn;
  end

  // capture register: compare with the level still held by launchQ
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) captureQ <= 1'b0;
    else       captureQ <= sampleQ ^ launchQ;
  end

  assign cycleNext = cycleQ + ONE;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      limitQ <= '0;
      cycleQ <= '0;
      errQ   <= '0;
    end else if (strobes.clearCounts) begin
      limitQ <= windowLen;
      cycleQ <= '0;
      errQ   <= '0;
    end else if (strobes.accumulate) begin
      cycleQ <= cycleNext;
      errQ   <= errQ + CNT_W'(captureQ);
    end
  end

  assign windowZero = (windowLen == '0);
  assign windowEnd  = (cycleNext == limitQ);
  assign launchOut  = launchQ;
  assign errFlag    = captureQ;
  assign errCount   = errQ;
  assign cycleCount = cycleQ;

endmodule

// File: rtl/tem_control.sv
module tem_control
  import tem_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       windowZero,
  input  logic       windowEnd,
  output ctlStrobe_t strobes,
  output logic       done
);

  winState_t stateQ;
  winState_t stateD;

  always_comb begin
    strobes.clearCounts = start;
    strobes.accumulate  = (stateQ == ST_RUN) && !start;
    stateD = stateQ;
    if (start) begin
      stateD = windowZero ? ST_FIN : ST_RUN;
    end else if ((stateQ == ST_RUN) && windowEnd) begin
      stateD = ST_FIN;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  assign done = (stateQ == ST_FIN);

endmodule

// File: rtl/timing_err_monitor.sv
module timing_err_monitor
  import tem_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [CNT_W-1:0] windowLen,
  input  logic             chainIn,
  output logic             launchOut,
  output logic             errFlag,
  output logic [CNT_W-1:0] errCount,
  output logic [CNT_W-1:0] cycleCount,
  output logic             done
);

  ctlStrobe_t strobes;
  logic       windowZero;
  logic       windowEnd;

  tem_control ctl_i (
    .clk        (clk),
    .rstN       (rstN),
    .start      (start),
    .windowZero (windowZero),
    .windowEnd  (windowEnd),
    .strobes    (strobes),
    .done       (done)
  );

  tem_datapath #(.CNT_W(CNT_W)) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .windowLen  (windowLen),
    .chainIn    (chainIn),
    .launchOut  (launchOut),
    .errFlag    (errFlag),
    .errCount   (errCount),
    .cycleCount (cycleCount),
    .windowZero (windowZero),
    .windowEnd  (windowEnd)
  );

endmodule

// File: rtl/tem_checker.sv
module tem_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             start,
  input logic             launchOut,
  input logic [CNT_W-1:0] errCount,
  input logic [CNT_W-1:0] cycleCount,
  input logic             done
);

  AST_LAUNCH_TOGGLE: assert property (@(posedge clk) disable iff (!rstN)
    rstN |=> (launchOut != $past(launchOut))); // R1

  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    start |=> (errCount == '0) && (cycleCount == '0)); // R4

  AST_CYCLE_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (!start && !done && (cycleCount != '0)) |=> (cycleCount == $past(cycleCount) + CNT_W'(1))); // R5

  AST_ERR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    !start |=> ((errCount == $past(errCount)) || (errCount == $past(errCount) + CNT_W'(1)))); // R5

  AST_DONE_FREEZE: assert property (@(posedge clk) disable iff (!rstN)
    (done && !start) |=> done && $stable(errCount) && $stable(cycleCount)); // R7

  AST_ERR_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    errCount <= cycleCount); // R10

endmodule

bind timing_err_monitor tem_checker #(.CNT_W(CNT_W)) chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .start      (start),
  .launchOut  (launchOut),
  .errCount   (errCount),
  .cycleCount (cycleCount),
  .done       (done)
);

// File: tb/timing_err_monitor_tb_top.sv
`timescale 1ns/1ps
module timing_err_monitor_tb_top;

  typedef struct {
    int    errExp;
    int    cycExp;
    longint doneEdge;
    string req;
  } item_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [15:0] windowLen = '0;
  logic        chainIn = 1'b0;
  logic        launchOut;
  logic        errFlag;
  logic [15:0] errCount;
  logic [15:0] cycleCount;
  logic        done;

  int total = 0;
  int bad = 0;
  int mode = 0;
  item_t sbq[$];

  timing_err_monitor dut_i (
    .clk        (clk),
    .rstN       (rstN),
    .start      (start),
    .windowLen  (windowLen),
    .chainIn    (chainIn),
    .launchOut  (launchOut),
    .errFlag    (errFlag),
    .errCount   (errCount),
    .cycleCount (cycleCount),
    .done       (done)
  );

  always #2 clk = ~clk;  // 250 MHz, rising edges at 2, 6, 10 ...

  // per-edge delay pattern: true means slower than half a period
  function automatic bit slowAt(input longint e);
    case (mode)
      0: return 1'b0;
      1: return 1'b1;
      2: return (e % 3) == 0;
      default: return (e % 5) < 2;
    endcase
  endfunction

  // external chain model: 1 ns when fast, 3 ns when slow (half period 2 ns)
  always @(launchOut) begin
    automatic longint e = ($time - 2) / 4;
    automatic logic   v = launchOut;
    if (slowAt(e)) #3; else #1;
    chainIn = v;
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // driver: issue a start pulse and push the expected result
  task automatic runWindow(input int n, input bit push, input string req);
    longint k;
    item_t  it;
    @(negedge clk);
    windowLen = 16'(n);
    start = 1'b1;
    @(posedge clk);
    k = ($time - 2) / 4;
    if (push) begin
      it.errExp = 0;
      for (longint e = k - 1; e <= k + n - 2; e++) it.errExp += int'(slowAt(e));
      it.cycExp   = n;
      it.doneEdge = k + n;
      it.req      = req;
      sbq.push_back(it);
    end
    #1 start = 1'b0;
  endtask

  task automatic waitDone();
    @(negedge clk);
    while (!done) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic setMode(input int m);
    mode = m;
    repeat (4) @(negedge clk);
  endtask

  // monitor: compare when done is seen with an item pending
  always @(negedge clk) begin
    if (sbq.size() > 0 && done) begin
      automatic item_t  it  = sbq.pop_front();
      automatic longint now = ($time - 4) / 4;
      check(errCount == 16'(it.errExp), {it.req, " R5 errCount"}, errCount, it.errExp);
      check(cycleCount == 16'(it.cycExp), {it.req, " R5 cycleCount"}, cycleCount, it.cycExp);
      check(now == it.doneEdge, {it.req, " R6 done edge"}, now, it.doneEdge);
    end
  end

  initial begin
    #1000000;
    total++;
    bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic prevLaunch;
    logic [15:0] eHold;
    logic [15:0] cHold;

    // R9 reset state
    repeat (3) @(negedge clk);
    check(launchOut == 1'b0, "R9 launchOut", launchOut, 0);
    check(errFlag == 1'b0, "R9 errFlag", errFlag, 0);
    check(errCount == '0 && cycleCount == '0, "R9 counts", errCount + cycleCount, 0);
    check(done == 1'b0, "R9 done", done, 0);
    rstN = 1'b1;

    // R1 launch toggles every edge
    @(negedge clk);
    prevLaunch = launchOut;
    check(launchOut == 1'b1, "R1 first launch", launchOut, 1);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(launchOut != prevLaunch, "R1 toggle", launchOut, !prevLaunch);
      prevLaunch = launchOut;
    end

    // R2 flag follows the per-edge pattern with one edge of lag
    setMode(2);
    for (int i = 0; i < 9; i++) begin
      automatic longint j;
      @(negedge clk);
      j = ($time - 4) / 4;
      check(errFlag == slowAt(j - 1), "R2 flag pattern", errFlag, slowAt(j - 1));
    end

    // R3 slow and fast chains
    setMode(1);
    check(errFlag == 1'b1, "R3 slow flag", errFlag, 1);
    runWindow(40, 1, "R3 slow");
    waitDone();
    setMode(0);
    check(errFlag == 1'b0, "R3 fast flag", errFlag, 0);
    runWindow(40, 1, "R3 fast");
    waitDone();

    // R5 patterned windows
    setMode(2);
    runWindow(30, 1, "R5 every third");
    waitDone();
    setMode(3);
    runWindow(25, 1, "R5 two of five");
    waitDone();

    // R7 freeze after done
    eHold = errCount;
    cHold = cycleCount;
    repeat (10) @(negedge clk);
    check(errCount == eHold, "R7 errCount frozen", errCount, eHold);
    check(cycleCount == cHold, "R7 cycleCount frozen", cycleCount, cHold);
    check(done == 1'b1, "R7 done held", done, 1);

    // R4 start clears counts, R6 done low during window
    runWindow(20, 1, "R4 R6 window");
    check(errCount == '0 && cycleCount == '0, "R4 cleared", errCount + cycleCount, 0);
    check(done == 1'b0, "R6 done low", done, 0);
    waitDone();

    // R6 single-cycle and empty windows
    runWindow(1, 1, "R6 one");
    waitDone();
    runWindow(0, 1, "R6 zero");
    waitDone();

    // R8 restart during an open window
    setMode(2);
    runWindow(50, 0, "R8 first");
    repeat (10) @(negedge clk);
    check(done == 1'b0, "R8 open", done, 0);
    runWindow(15, 1, "R8 restart");
    waitDone();

    check(sbq.size() == 0, "R5 scoreboard drained", sbq.size(), 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule